// File: doc/BRIEF.md
# Attached Sprite Colour Mixer

This block takes the current pixel from eight hardware sprites and reduces it to one colour-register index in the upper half of a 32-entry palette, or reports that no sprite covers the pixel. The sprites are handled as four pairs. Pair p holds even sprite 2p and odd sprite 2p+1 and owns the four-register group starting at 16+4p. Each sprite gives two data bits per pixel. A per-pair attach flag, owned by the odd sprite, joins the two sprites into one sprite with a 4-bit value.

Pairs are checked in ascending order, and the first pair that yields a visible colour wins. The result is registered, and it updates on the clock edge where the pixel-valid strobe is high. When the strobe is low the last result is held. Playfield priority and palette lookup happen downstream and take `col_idx` and `hit` from this block.

Top module: `spr_mixer`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, `col_idx` is 0 and `hit` is 0.
- R2: In an unattached pair p, a nonzero even-sprite value v = {B,A}, where B is the sprite's `spr_b` bit and A its `spr_a` bit, gives `col_idx` = 16+4p+v with `hit` = 1.
- R3: In an unattached pair p whose even sprite shows 0, a nonzero odd-sprite value v gives `col_idx` = 16+4p+v.
- R4: In an unattached pair where both sprites are nonzero, the even sprite's value is used.
- R5: In an attached pair, the index is 16 + {odd B, odd A, even B, even A}, with odd B as bit 3. So odd A=0 with odd B=1 always gives 24 to 27.
- R6: An attached pair whose 4-bit value is 0 is transparent, and lower-priority pairs show through it.
- R7: When several pairs are visible, the lowest-numbered pair sets the output.
- R8: When no pair is visible, `hit` is 0 and `col_idx` is 0.
- R9: Outputs change only on the clock edge after a cycle with `pix_valid` = 1. With `pix_valid` = 0 they hold their value whatever the other inputs do.
- R10: The attach flag of one pair has no effect on how any other pair is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Strobe: sample this pixel's sprite data |
| spr_a | input | 8 | Data A bit of each sprite, sprite n at bit n |
| spr_b | input | 8 | Data B bit of each sprite, sprite n at bit n |
| attach | input | 4 | Attach flag for each pair, pair p at bit p |
| col_idx | output | 5 | Winning colour-register index, 0 when none |
| hit | output | 1 | A sprite covers this pixel |

## Verification
On every cycle the assertions check the following: holding while the strobe is low, the fixed 24-27 window for a pair-0 attached odd value of A=0, B=1, the direct even-sprite mapping of pair 0, the zero result with no sprite data, and that any hit lies in the upper palette half. Some behaviours only show up in the bench's scenarios. These are priority between different pairs, an attached pair of value zero letting a later pair through, even-over-odd resolution, and the isolation of each pair's attach flag.

// File: rtl/spr_mixer.sv
module spr_mixer #(
  parameter int NUM_PAIRS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pix_valid,
  input  logic [2*NUM_PAIRS-1:0]    spr_a,
  input  logic [2*NUM_PAIRS-1:0]    spr_b,
  input  logic [NUM_PAIRS-1:0]      attach,
  output logic [$clog2(NUM_PAIRS*4)+0:0] col_idx,
  output logic                      hit
);
  localparam int IDX_W = $clog2(NUM_PAIRS*4) + 1;
  localparam int BASE  = NUM_PAIRS * 4;

  logic [IDX_W-1:0] cand_idx [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] cand_hit;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam logic [IDX_W-1:0] GRP = IDX_W'(BASE + 4*p);
    wire [1:0] ev  = {spr_b[2*p],   spr_a[2*p]};
    wire [1:0] od  = {spr_b[2*p+1], spr_a[2*p+1]};
    wire [3:0] wide = {od, ev};
    wire [1:0] sel = (ev != 2'd0) ? ev : od;
    wire [IDX_W-1:0] solo_idx = GRP + {{(IDX_W-2){1'b0}}, sel};
    wire [IDX_W-1:0] join_idx = IDX_W'(BASE) + {{(IDX_W-4){1'b0}}, wide};
    assign cand_idx[p] = attach[p] ? join_idx : solo_idx;
    assign cand_hit[p] = attach[p] ? (wide != 4'd0) : (sel != 2'd0);
  end

  logic [IDX_W-1:0] nxt_idx;
  logic nxt_hit;

  always_comb begin
    nxt_idx = '0;
    nxt_hit = 1'b0;
    for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
      if (cand_hit[p]) begin
        nxt_idx = cand_idx[p];
        nxt_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_idx <= '0;
      hit     <= 1'b0;
    end else if (pix_valid) begin
      col_idx <= nxt_idx;
      hit     <= nxt_hit;
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> ($stable(col_idx) && $stable(hit)));

  // R5
  attach_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && attach[0] && spr_b[1] && !spr_a[1]) |=> (hit && col_idx[IDX_W-1:2] == 3'b110));

  // R2
  even_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !attach[0] && (spr_a[0] || spr_b[0])) |=>
      (hit && col_idx == IDX_W'(BASE) + {{(IDX_W-2){1'b0}}, $past(spr_b[0]), $past(spr_a[0])}));

  // R8
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && spr_a == '0 && spr_b == '0) |=> (!hit && col_idx == '0));

  // R8
  upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> col_idx[IDX_W-1]);
endmodule

// File: tb/spr_mixer_bench.sv
module spr_mixer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_valid = 1'b0;
  logic [7:0] spr_a = '0, spr_b = '0;
  logic [3:0] attach = '0;
  logic [4:0] col_idx;
  logic hit;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spr_mixer u_spr_mixer (.clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
    .spr_a(spr_a), .spr_b(spr_b), .attach(attach), .col_idx(col_idx), .hit(hit));

  // {spr_a, spr_b, attach, exp_idx, exp_hit}
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {8'h01, 8'h00, 4'h0, 5'd17, 1'b1},
    {8'h01, 8'h01, 4'h0, 5'd19, 1'b1},
    {8'h00, 8'h04, 4'h0, 5'd22, 1'b1},
    {8'h02, 8'h00, 4'h0, 5'd17, 1'b1},
    {8'h80, 8'h80, 4'h0, 5'd31, 1'b1},
    {8'h02, 8'h03, 4'h0, 5'd18, 1'b1},
    {8'h01, 8'h02, 4'h1, 5'd25, 1'b1},
    {8'h20, 8'h30, 4'h4, 5'd30, 1'b1},
    {8'h08, 8'h00, 4'h1, 5'd21, 1'b1},
    {8'h44, 8'h40, 4'h0, 5'd21, 1'b1},
    {8'h06, 8'h04, 4'h1, 5'd20, 1'b1},
    {8'h00, 8'h00, 4'hF, 5'd0,  1'b0},
    {8'h00, 8'h40, 4'h8, 5'd18, 1'b1},
    {8'h00, 8'h02, 4'h2, 5'd18, 1'b1}
  };

  function automatic string req_of(int i);
    case (i)
      0, 1, 2: return "R2";
      3, 4:    return "R3";
      5:       return "R4";
      6, 7, 12: return "R5";
      8:       return "R6";
      9, 10:   return "R7";
      11:      return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [4:0] gi, logic gh, logic [4:0] ei, logic eh);
    checks++;
    if (gi !== ei || gh !== eh) begin
      failures++;
      $display("FAIL %s: got idx=%0d hit=%0b, expected idx=%0d hit=%0b", req, gi, gh, ei, eh);
    end
  endtask

  task automatic apply(logic [7:0] a, logic [7:0] b, logic [3:0] at, logic v);
    @(negedge clk);
    spr_a = a; spr_b = b; attach = at; pix_valid = v;
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", col_idx, hit, 5'd0, 1'b0);
    @(negedge clk); spr_a = 8'hFF; spr_b = 8'hFF; pix_valid = 1'b1;
    @(negedge clk);
    check("R1", col_idx, hit, 5'd0, 1'b0);
    pix_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", col_idx, hit, 5'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][25:18], VEC[i][17:10], VEC[i][9:6], 1'b1);
      check(req_of(i), col_idx, hit, VEC[i][5:1], VEC[i][0]);
    end

    // R9: hold with strobe low, then update on strobe
    apply(8'h01, 8'h01, 4'h0, 1'b1);
    check("R9", col_idx, hit, 5'd19, 1'b1);
    apply(8'h00, 8'h80, 4'h0, 1'b0);
    @(negedge clk);
    check("R9", col_idx, hit, 5'd19, 1'b1);
    @(negedge clk); spr_a = 8'h00; spr_b = 8'h00; pix_valid = 1'b1;
    @(posedge clk); #1;
    check("R9", col_idx, hit, 5'd0, 1'b0);
    pix_valid = 1'b0;

    // R5: odd A=0,B=1 forces 24..27 for each even value
    for (int e = 0; e < 4; e++) begin
      apply({7'b0, e[0]}, {6'b0, 1'b1, e[1]}, 4'h1, 1'b1);
      check("R5", col_idx, hit, 5'(24 + e), 1'b1);
    end

    // R6: attached pair 0 empty, pair 3 odd visible
    apply(8'h80, 8'h00, 4'h1, 1'b1);
    check("R6", col_idx, hit, 5'd29, 1'b1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule